// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Timer

This block holds a set of PWM timer channels (five by default) that share one 32-bit control word. Each channel has a period buffer and a threshold buffer that software writes at any time. These values reach the running down counter at only two moments: while the channel's load bit is held, or when the counter expires with its repeat bit set. Because of this, a new period and duty can be staged without disturbing the period that is in progress. The counter steps once per strobe on the `tick` input, which comes from a separate clock divider. Each channel drives one PWM pin and gives a one-clock expiry pulse.

Software brings a channel up in two writes. The first sets the load bit and leaves the run bit clear, which copies both buffers into the counter. The second clears the load bit and sets the run and repeat bits. To stop the channel cleanly, software clears the repeat bit: the current period finishes and the channel then parks with its output inactive.

Register writes use a single-cycle strobe. Address 0 is the control word. Channel k takes its period buffer at address 2k+1 and its threshold buffer at address 2k+2. Data is truncated to the counter width.

Top module: `dbpwm_timer`

## Requirements
- R1: While reset is asserted, and right after it is released, every PWM pin and every expiry pulse is 0 and the control word is 0.
- R2: Holding the load bit copies the period and threshold buffers into the counter and holds it there. Setting the run bit on a channel that has never been loaded leaves its pin inactive and raises no expiry pulse.
- R3: With run and repeat set and a period buffer of N ≥ 1, the expiry pulse is exactly one clock long and comes once every N+1 tick strobes.
- R4: Within each period, the raw output is active while the count is above the threshold C. That gives N−C active ticks out of N+1.
- R5: A threshold of all ones (16'hFFFF at the default width) keeps the output active for every tick of the period.
- R6: A period buffer of 0 is invalid. Loading it leaves the channel disarmed, with its pin inactive and no expiry pulse.
- R7: When the inverter bit is set, the pin is the complement of the raw output. This includes the idle level, which becomes 1.
- R8: If the repeat bit is cleared while a channel runs, exactly one more expiry happens. After that the counter stops and the pin stays inactive.
- R9: A buffer write made during a run does not change the period in progress. It takes effect from the next reload.
- R10: Control bit layout: channel 0 uses bits [3:0] (run=0, load=1, invert=2, repeat=3). Channel k ≥ 1 uses the same layout in the nibble starting at bit 4(k+1). Bits [7:4] have no effect.
- R11: Channel 4 has no inverter. Its repeat bit is bit 22 (run=20, load=21), and bit 23 has no effect.
- R12: The counter changes only on clock cycles where `tick` is 1, or on cycles where load is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count strobe from the clock divider |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 is the control word, 2k+1 is the period buffer of channel k, 2k+2 is its threshold buffer |
| wr_data | input | 32 | Write data |
| pwm_out | output | NUM_CH | PWM pins, one per channel |
| irq | output | NUM_CH | One-clock expiry pulses, one per channel |

## Verification
A wrong count or a stale threshold inside a channel shows on its pin in the first period after the fault: a high time off by one tick, or an expiry pulse one tick early or late. A missed reload shows within one period as a changed period length. The bench runs a behavioural model of each channel alongside the design and compares every pin and pulse on every clock, so a divergence is reported in the cycle where it first appears. The irregular control bit positions show at once as a channel that fails to start or that runs with the wrong polarity.

// File: rtl/dbpwm_pkg.sv
package dbpwm_pkg;

   // Per-channel control bits after the shared control word is decoded
   typedef struct packed {
      logic run;
      logic load;
      logic invert;
      logic repeat_en;
   } chan_ctl_t;

   // Channel whose repeat bit is irregular and which has no inverter
   localparam int ODD_CH = 4;

   // Bit position of the channel's run bit: slot 1 is skipped after channel 0
   function automatic int nib_base(input int k);
      return (k == 0) ? 0 : 4 * (k + 1);
   endfunction

   function automatic int repeat_pos(input int k);
      return (k == ODD_CH) ? nib_base(k) + 2 : nib_base(k) + 3;
   endfunction

   function automatic bit has_invert(input int k);
      return k != ODD_CH;
   endfunction

   // Mask of all control word bits that channels 0..n-1 use
   function automatic logic [31:0] used_mask(input int n);
      logic [31:0] m;
      m = '0;
      for (int k = 0; k < n; k++) begin
         m[nib_base(k)]     = 1'b1;
         m[nib_base(k) + 1] = 1'b1;
         m[repeat_pos(k)]   = 1'b1;
         if (has_invert(k)) m[nib_base(k) + 2] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/dbpwm_ctl_decode.sv
module dbpwm_ctl_decode
   import dbpwm_pkg::*;
#(
   parameter int NUM_CH = 5
) (
   input  logic [31:0]                  ctl_word,
   output chan_ctl_t [NUM_CH-1:0]       ctl_o
);

   localparam logic [31:0] USED = used_mask(NUM_CH);

   // Bits no channel decodes are folded away on purpose
   logic unused_ctl_bits;
   assign unused_ctl_bits = ^(ctl_word & ~USED);

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      localparam int B  = nib_base(k);
      localparam int RP = repeat_pos(k);
      assign ctl_o[k].run       = ctl_word[B];
      assign ctl_o[k].load      = ctl_word[B + 1];
      assign ctl_o[k].repeat_en = ctl_word[RP];
      if (has_invert(k)) begin : g_inv
         assign ctl_o[k].invert = ctl_word[B + 2];
      end else begin : g_noinv
         assign ctl_o[k].invert = 1'b0;
      end
   end

endmodule

// File: rtl/dbpwm_regs.sv
module dbpwm_regs #(
   parameter int NUM_CH = 5,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  logic [31:0]                      wr_data,
   output logic [31:0]                      ctl_word,
   output logic [NUM_CH-1:0][CNT_W-1:0]     per_buf,
   output logic [NUM_CH-1:0][CNT_W-1:0]     thr_buf
);

   logic [CNT_W-1:0] wdat;
   assign wdat = wr_data[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_word <= '0;
         per_buf  <= '0;
         thr_buf  <= '0;
      end else if (wr_en) begin
         if (wr_addr == '0) ctl_word <= wr_data;
         for (int k = 0; k < NUM_CH; k++) begin
            if (wr_addr == ADDR_W'(2 * k + 1)) per_buf[k] <= wdat;
            if (wr_addr == ADDR_W'(2 * k + 2)) thr_buf[k] <= wdat;
         end
      end
   end

endmodule

// File: rtl/dbpwm_chan.sv
module dbpwm_chan
   import dbpwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  chan_ctl_t        ctl,
   input  logic [CNT_W-1:0] per_buf,
   input  logic [CNT_W-1:0] thr_buf,
   output logic             pwm_o,
   output logic             irq_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             live_o
);

   logic [CNT_W-1:0] cnt_q, thr_q;
   logic             live_q, irq_q;
   logic             expire, full_duty, active;

   assign expire = ctl.run && !ctl.load && live_q && tick && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         thr_q  <= '0;
         live_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= expire;
         if (ctl.load) begin
            cnt_q  <= per_buf;
            thr_q  <= thr_buf;
            live_q <= (per_buf != '0);
         end else if (ctl.run && live_q && tick) begin
            if (cnt_q == '0) begin
               if (ctl.repeat_en) begin
                  cnt_q  <= per_buf;
                  thr_q  <= thr_buf;
                  live_q <= (per_buf != '0);
               end else begin
                  live_q <= 1'b0;
               end
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   assign full_duty = &thr_q;
   assign active    = ctl.run && live_q && !ctl.load && (full_duty || (cnt_q > thr_q));
   assign pwm_o     = active ^ ctl.invert;
   assign irq_o     = irq_q;
   assign cnt_o     = cnt_q;
   assign live_o    = live_q;

endmodule

// File: rtl/dbpwm_timer.sv
module dbpwm_timer
   import dbpwm_pkg::*;
#(
   parameter  int CNT_W  = 16,
   parameter  int NUM_CH = 5,
   localparam int ADDR_W = $clog2(2 * NUM_CH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   output logic [NUM_CH-1:0] pwm_out,
   output logic [NUM_CH-1:0] irq
);

   if (!(CNT_W == 16 || CNT_W == 32)) begin : g_bad_width
      $error("dbpwm_timer: CNT_W must be 16 or 32");
   end
   if (NUM_CH < 1 || NUM_CH > 5) begin : g_bad_count
      $error("dbpwm_timer: NUM_CH must be 1 to 5");
   end

   logic [31:0]                  ctl_word;
   logic [NUM_CH-1:0][CNT_W-1:0] per_buf_w, thr_buf_w, act_cnt_w;
   chan_ctl_t [NUM_CH-1:0]       ctl;
   logic [NUM_CH-1:0]            load_vec, live_vec;

   dbpwm_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .ctl_word (ctl_word),
      .per_buf  (per_buf_w),
      .thr_buf  (thr_buf_w)
   );

   dbpwm_ctl_decode #(.NUM_CH(NUM_CH)) dec_i (
      .ctl_word (ctl_word),
      .ctl_o    (ctl)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
      assign load_vec[k] = ctl[k].load;
      dbpwm_chan #(.CNT_W(CNT_W)) chan_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick),
         .ctl     (ctl[k]),
         .per_buf (per_buf_w[k]),
         .thr_buf (thr_buf_w[k]),
         .pwm_o   (pwm_out[k]),
         .irq_o   (irq[k]),
         .cnt_o   (act_cnt_w[k]),
         .live_o  (live_vec[k])
      );
   end

endmodule

// File: rtl/dbpwm_timer_chk.sv
module dbpwm_timer_chk #(
   parameter int NUM_CH = 5,
   parameter int CNT_W  = 16
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         tick,
   input logic [NUM_CH-1:0]            irq_o,
   input logic [NUM_CH-1:0]            load_v,
   input logic [NUM_CH-1:0]            live_v,
   input logic [NUM_CH-1:0][CNT_W-1:0] act_cnt,
   input logic [NUM_CH-1:0][CNT_W-1:0] per_buf
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (irq_o == '0));

   for (genvar k = 0; k < NUM_CH; k++) begin : g_k
      // R3
      pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[k] |=> !irq_o[k]);
      // R12
      pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[k] |-> $past(tick));
      // R12
      count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!tick && !load_v[k]) |=> $stable(act_cnt[k]));
      // R6
      zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (load_v[k] && per_buf[k] == '0) |=> !live_v[k]);
   end

endmodule

bind dbpwm_timer dbpwm_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .irq_o   (irq),
   .load_v  (load_vec),
   .live_v  (live_vec),
   .act_cnt (act_cnt_w),
   .per_buf (per_buf_w)
);

// File: tb/dbpwm_timer_tb_top.sv
module dbpwm_timer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [4:0]  pwm_out, irq;

   int n_run = 0, n_fail = 0, cyc = 0, tick_div = 1, tcount = 0;
   string cur_req = "R1";
   bit   started = 1'b0;

   always #2 clk = ~clk;

   dbpwm_timer dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out), .irq(irq)
   );

   // Control bit positions per channel, written out independently
   int p_run[5] = '{0, 8, 12, 16, 20};
   int p_ld[5]  = '{1, 9, 13, 17, 21};
   int p_inv[5] = '{2, 10, 14, 18, -1};
   int p_rep[5] = '{3, 11, 15, 19, 22};

   // Behavioural reference model
   logic [31:0] m_ctl = '0;
   logic [15:0] m_per[5] = '{default: '0};
   logic [15:0] m_thr[5] = '{default: '0};
   logic [15:0] m_cnt[5] = '{default: '0};
   logic [15:0] m_th[5]  = '{default: '0};
   bit          m_live[5] = '{default: 1'b0};
   bit          m_irq[5]  = '{default: 1'b0};

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctl = '0;
         for (int k = 0; k < 5; k++) begin
            m_per[k] = 0; m_thr[k] = 0; m_cnt[k] = 0; m_th[k] = 0;
            m_live[k] = 0; m_irq[k] = 0;
         end
      end else begin
         for (int k = 0; k < 5; k++) begin
            bit run, ld, rep;
            run = m_ctl[p_run[k]]; ld = m_ctl[p_ld[k]]; rep = m_ctl[p_rep[k]];
            m_irq[k] = 0;
            if (ld) begin
               m_cnt[k] = m_per[k]; m_th[k] = m_thr[k]; m_live[k] = (m_per[k] != 0);
            end else if (run && m_live[k] && tick) begin
               if (m_cnt[k] == 0) begin
                  m_irq[k] = 1;
                  if (rep) begin
                     m_cnt[k] = m_per[k]; m_th[k] = m_thr[k]; m_live[k] = (m_per[k] != 0);
                  end else m_live[k] = 0;
               end else m_cnt[k] = m_cnt[k] - 1;
            end
         end
         if (wr_en) begin
            if (wr_addr == 0) m_ctl = wr_data;
            for (int k = 0; k < 5; k++) begin
               if (wr_addr == 2 * k + 1) m_per[k] = wr_data[15:0];
               if (wr_addr == 2 * k + 2) m_thr[k] = wr_data[15:0];
            end
         end
      end
   end

   function automatic logic [9:0] model_out();
      logic [4:0] p, q;
      for (int k = 0; k < 5; k++) begin
         bit act, inv;
         inv = (p_inv[k] >= 0) ? m_ctl[p_inv[k]] : 1'b0;
         act = m_ctl[p_run[k]] && m_live[k] && !m_ctl[p_ld[k]] &&
               (m_th[k] == 16'hFFFF || m_cnt[k] > m_th[k]);
         p[k] = act ^ inv;
         q[k] = m_irq[k];
      end
      return {q, p};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Tick strobe generator and per-clock comparison with the model
   always @(negedge clk) begin
      tcount <= tcount + 1;
      tick   <= (tick_div == 1) || (tcount % tick_div == 0);
      if (started) chk(cur_req, {22'd0, irq, pwm_out}, {22'd0, model_out()});
   end

   // Watchdog
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
         $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
         $finish;
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_irq(input int k);
      do @(negedge clk); while (!irq[k]);
   endtask

   task automatic window(input int n, input int k, output int hi, output int ni);
      hi = 0; ni = 0;
      repeat (n) begin
         @(negedge clk);
         hi += int'(pwm_out[k]);
         ni += int'(irq[k]);
      end
   endtask

   function automatic logic [31:0] cw(input int k, input bit run, ld, inv, rep);
      logic [31:0] w = '0;
      w[p_run[k]] = run; w[p_ld[k]] = ld; w[p_rep[k]] = rep;
      if (p_inv[k] >= 0) w[p_inv[k]] = inv;
      return w;
   endfunction

   initial begin
      int hi, ni;
      repeat (4) @(negedge clk);
      chk("R1", {22'd0, irq, pwm_out}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {22'd0, irq, pwm_out}, 32'd0);
      started = 1'b1;

      cur_req = "R2";
      wr(1, 9); wr(2, 3);
      wr(0, cw(0, 1, 0, 0, 1));
      window(20, 0, hi, ni);
      chk("R2", hi, 0); chk("R2", ni, 0);
      wr(0, cw(0, 0, 1, 0, 0));
      wr(0, cw(0, 1, 0, 0, 1));

      cur_req = "R3";
      wait_irq(0); window(10, 0, hi, ni);
      chk("R3", ni, 1); chk("R4", hi, 6);

      cur_req = "R12";
      tick_div = 3;
      wait_irq(0); wait_irq(0); window(30, 0, hi, ni);
      chk("R12", ni, 1); chk("R12", hi, 18);
      tick_div = 1;

      cur_req = "R9";
      wr(1, 4); wr(2, 1);
      wait_irq(0); wait_irq(0); wait_irq(0); window(5, 0, hi, ni);
      chk("R9", hi, 3); chk("R9", ni, 1);

      cur_req = "R5";
      wr(2, 32'h0000FFFF);
      wait_irq(0); wait_irq(0); window(5, 0, hi, ni);
      chk("R5", hi, 5);

      cur_req = "R7";
      wr(2, 1); wr(0, cw(0, 1, 0, 1, 1));
      wait_irq(0); wait_irq(0); window(5, 0, hi, ni);
      chk("R7", hi, 2);
      wr(0, cw(0, 0, 0, 1, 0));
      @(negedge clk);
      chk("R7", pwm_out[0], 1);

      cur_req = "R10";
      wr(0, 32'h000000F0);
      window(20, 0, hi, ni);
      chk("R10", hi, 0); chk("R10", ni, 0);
      chk("R10", pwm_out, 0);

      cur_req = "R8";
      wr(3, 5); wr(4, 2);
      wr(0, cw(1, 0, 1, 0, 0));
      wr(0, cw(1, 1, 0, 0, 1));
      wait_irq(1); window(6, 1, hi, ni);
      chk("R10", hi, 3); chk("R10", ni, 1);
      wr(0, cw(1, 1, 0, 0, 0));
      window(40, 1, hi, ni);
      chk("R8", ni, 1);
      window(10, 1, hi, ni);
      chk("R8", hi, 0); chk("R8", ni, 0);

      cur_req = "R11";
      wr(0, 0); wr(9, 3); wr(10, 0);
      wr(0, 32'h00200000);
      wr(0, 32'h00D00000);
      wait_irq(4); window(8, 4, hi, ni);
      chk("R11", ni, 2); chk("R11", hi, 6);
      wr(0, 32'h00900000);
      window(20, 4, hi, ni);
      chk("R11", ni, 1);
      window(10, 4, hi, ni);
      chk("R11", hi, 0);

      cur_req = "R6";
      wr(0, 0); wr(5, 0); wr(6, 0);
      wr(0, cw(2, 0, 1, 0, 0));
      wr(0, cw(2, 1, 0, 0, 1));
      window(20, 2, hi, ni);
      chk("R6", hi, 0); chk("R6", ni, 0);

      started = 1'b0;
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule